// File: doc/BRIEF.md
# Microcoded Layer Sequencer

This block is the control engine of one neural processing unit. It runs a
static schedule held in a small local microcode store. Each microcode word
describes one burst of multiply-add commands. The word gives the logical
(architectural) element that runs the burst, the number of operations, where
the operands come from, and where the results go. The sequencer maps the
logical element onto a physical element of the processing chain. Because of
this mapping, one program runs unchanged on chains of different length. The
arithmetic itself lives outside the block.

Operands come from one of two places: an external input FIFO, or an internal
sigmoid FIFO. The sigmoid FIFO holds the activation results of a hidden layer
so that the next layer can consume them. Results of the output layer skip
that FIFO and go straight to the output port.

Software loads the program through a simple write port while the unit is
idle. It then flips the start-event line. When every output has been
delivered, the unit flips its done-event line. Issue stalls whenever the
chosen operand source is empty or the chosen destination has no room.

Top module: `layer_seq`

## Requirements
- R1: Reset is synchronous and active low. While reset is held, and in the first cycle after it, `busy`, `cmd_valid`, `in_pop` and `out_valid` are 0 and `done_evt` is 0.
- R2: A change of level on `start_evt` (either direction) seen while idle starts a run from microcode address 0, and `busy` rises in the next cycle. A change of level while busy is ignored and does not cause a later run.
- R3: A microcode write (`cfg_we`, `cfg_addr`, `cfg_wdata`) takes effect only while `busy` is 0. A write while busy leaves the stored program unchanged.
- R4: The microcode word layout is fixed. Bit 31 set marks the end of the program. Bits 7:0 hold the architectural element ID. Bits 17:8 hold the multiply-add count. Bit 18 selects the source (0 = input FIFO, 1 = sigmoid FIFO). Bit 19 selects the destination (0 = next element, 1 = activation unit). Bits 21:20 hold the activation type. Bit 22 is the output-layer flag. Bits 30:23 are unused.
- R5: Words run in address order from 0. Each word costs one fetch cycle and then issues its count of commands, one per cycle that is not stalled. A word with count 0 is skipped after its fetch cycle. `cmd_valid` is never high while idle.
- R6: `cmd_pe` equals the architectural element ID modulo `NUM_PE`.
- R7: With source 0, each command pops the input FIFO (`in_pop`) and carries `in_data`. With source 1, each command pops the sigmoid FIFO and carries its oldest entry.
- R8: `cmd_to_act` repeats the destination bit. When the destination is the activation unit, `cmd_act_type` and `cmd_out_layer` repeat bits 21:20 and bit 22. When the destination is the next element, both fields are 0.
- R9: A returned activation result (`act_valid`) with `act_last` = 0 is pushed into the sigmoid FIFO. A result with `act_last` = 1 appears on `out_valid`/`out_data` in the same cycle. The sigmoid FIFO is `SIG_DEPTH` entries of 16 bits (default 1024).
- R10: Issue stalls while the selected source FIFO is empty. The sigmoid FIFO has no same-cycle bypass from a push to a pop.
- R11: Some commands send a hidden-layer result to the activation unit. Such a command stalls when the FIFO occupancy, plus the hidden-layer results still in flight, minus one if the command itself pops the sigmoid FIFO, is not below `SIG_DEPTH`. An output-layer command stalls while `out_full` is 1. A command bound for the next element never stalls on `out_full`.
- R12: After fetching the end marker, the unit waits until no activation result is outstanding. It then toggles `done_evt` once and returns to idle, so `busy` falls in the same cycle that `done_evt` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Microcode write strobe |
| cfg_addr | input | PC_W | Microcode write address |
| cfg_wdata | input | 32 | Microcode word |
| start_evt | input | 1 | Start event, acts on a change of level |
| done_evt | output | 1 | Done event, changes level once per completed run |
| busy | output | 1 | Unit is running a program |
| in_valid | input | 1 | Input FIFO holds data |
| in_data | input | DATA_W | Input FIFO head |
| in_pop | output | 1 | Consume the input FIFO head |
| cmd_valid | output | 1 | Multiply-add command issued this cycle |
| cmd_pe | output | PE_W | Physical element index |
| cmd_data | output | DATA_W | Operand for the command |
| cmd_to_act | output | 1 | Result goes to the activation unit |
| cmd_act_type | output | 2 | Activation function selector |
| cmd_out_layer | output | 1 | Command belongs to the output layer |
| act_valid | input | 1 | Activation result returned |
| act_data | input | DATA_W | Activation result value |
| act_last | input | 1 | Result belongs to the output layer |
| out_full | input | 1 | Output memory interface cannot take more |
| out_valid | output | 1 | Output-layer result delivered |
| out_data | output | DATA_W | Output-layer result value |

## Verification
The bench fills the sigmoid FIFO to exactly its depth and then asks for one
more hidden-layer command. A design with an off-by-one error in the room check
would either issue that command and overflow the FIFO, or stall one command
too early. Input gaps and bursts of `out_full` make the bench compare every
issue cycle against its reference model. A design that ignored either stall
would pop empty data or push outputs that cannot be taken.

The bench also flips `start_evt` and writes the microcode during a run. It then
checks that no second run follows and that the program is unchanged when it
runs again. A design that latched those events would show an extra `busy`
period or a different command stream.

A word with count 0 is placed mid-program to check that it is skipped without
stalling the unit. Physical-element IDs above `NUM_PE` check that the modulo
mapping is applied. A mid-run reset confirms that `busy` and `done_evt` return
to their reset values.

// File: rtl/lseq_pkg.sv
`timescale 1ns/100ps
// Shared types for the layer sequencer: FSM states and the microcode word.
package lseq_pkg;
    localparam int WORD_W = 32;
    localparam int MADD_W = 10;
    localparam int ID_W   = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_t;

    // Microcode word; the bit positions are decoded by the control FSM.
    typedef struct packed {
        logic              stop;      // [31] end of program
        logic [7:0]        spare;     // [30:23]
        logic              out_layer; // [22]
        logic [1:0]        act_type;  // [21:20]
        logic              to_act;    // [19] 1 = activation unit
        logic              from_sig;  // [18] 1 = sigmoid FIFO
        logic [MADD_W-1:0] madd;      // [17:8]
        logic [ID_W-1:0]   arch_id;   // [7:0]
    } uword_t;
endpackage

// File: rtl/lseq_ucode_mem.sv
// Microcode store: one write port, one combinational read port.
// Assumes the caller gates writes; contents are not reset.
module lseq_ucode_mem #(
    parameter int DEPTH  = 256,
    parameter int WIDTH  = 32,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] words [DEPTH];

    // Store a word on a gated write.
    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/lseq_sig_fifo.sv
// Sigmoid FIFO: holds hidden-layer activation results for the next layer.
// Assumes no push when full and no pop when empty; a push is not visible
// at the head until the cycle after it.
module lseq_sig_fifo #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Write the data array.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= din;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout = store[rd_ptr];
endmodule

// File: rtl/lseq_ctrl.sv
// Control FSM: detects the start toggle, fetches microcode words, issues
// command bursts with source/destination stalls, tracks in-flight
// activation results, and toggles done when the program has drained.
// Assumes the activation unit returns exactly one result per issued
// activation command.
module lseq_ctrl
    import lseq_pkg::*;
#(
    parameter int PC_W      = 8,
    parameter int SIG_DEPTH = 1024,
    parameter int CNT_W     = 11,
    parameter int OUT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_evt,
    input  uword_t           word,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] sig_count,
    input  logic             out_full,
    input  logic             act_valid,
    input  logic             act_last,
    output logic [PC_W-1:0]  pc,
    output uword_t           cur,
    output logic             fire,
    output logic             busy,
    output logic             done_evt,
    output logic [CNT_W-1:0] infl_sig,
    output logic [OUT_W-1:0] infl_out
);
    seq_state_t        state;
    logic [MADD_W-1:0] rem;
    logic              start_seen;
    logic              src_ok;
    logic              room_sig;
    logic              dst_ok;
    logic              issue_sig;
    logic              issue_out;

    // Operand availability for the current word.
    assign src_ok   = cur.from_sig ? (sig_count != '0) : in_valid;
    // A self-consuming command frees the slot it fills.
    assign room_sig = (int'(sig_count) + int'(infl_sig) - int'(cur.from_sig)) < SIG_DEPTH;
    assign dst_ok   = !cur.to_act ? 1'b1 : (cur.out_layer ? !out_full : room_sig);
    assign fire     = (state == ST_ISSUE) && src_ok && dst_ok;
    assign busy     = (state != ST_IDLE);

    assign issue_sig = fire && cur.to_act && !cur.out_layer;
    assign issue_out = fire && cur.to_act && cur.out_layer;

    // Count activation results still owed by the activation unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            infl_sig <= '0;
            infl_out <= '0;
        end else begin
            infl_sig <= infl_sig + CNT_W'(issue_sig) - CNT_W'(act_valid && !act_last);
            infl_out <= infl_out + OUT_W'(issue_out) - OUT_W'(act_valid && act_last);
        end
    end

    // Sequence through the program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pc         <= '0;
            rem        <= '0;
            cur        <= '0;
            start_seen <= 1'b0;
            done_evt   <= 1'b0;
        end else begin
            start_seen <= start_evt;
            unique case (state)
                ST_IDLE: begin
                    if (start_evt != start_seen) begin
                        pc    <= '0;
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (word.stop) begin
                        state <= ST_DRAIN;
                    end else if (word.madd == '0) begin
                        pc <= pc + PC_W'(1);
                    end else begin
                        cur   <= word;
                        rem   <= word.madd;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (fire) begin
                        if (rem == MADD_W'(1)) begin
                            pc    <= pc + PC_W'(1);
                            state <= ST_LOAD;
                        end else begin
                            rem <= rem - MADD_W'(1);
                        end
                    end
                end
                ST_DRAIN: begin
                    if (infl_sig == '0 && infl_out == '0) begin
                        done_evt <= ~done_evt;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/layer_seq.sv
// Layer sequencer top: ties the microcode store, the control FSM and the
// sigmoid FIFO together, maps architectural IDs to physical elements and
// routes activation results to the FIFO or the output port.
// Assumes out_full covers every output-layer result still in flight.
module layer_seq
    import lseq_pkg::*;
#(
    parameter int NUM_PE      = 8,
    parameter int UCODE_DEPTH = 256,
    parameter int SIG_DEPTH   = 1024,
    parameter int DATA_W      = 16,
    parameter int OUT_W       = 16,
    localparam int PC_W  = (UCODE_DEPTH > 1) ? $clog2(UCODE_DEPTH) : 1,
    localparam int PE_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int CNT_W = $clog2(SIG_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PC_W-1:0]   cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              start_evt,
    output logic              done_evt,
    output logic              busy,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_pop,
    output logic              cmd_valid,
    output logic [PE_W-1:0]   cmd_pe,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_to_act,
    output logic [1:0]        cmd_act_type,
    output logic              cmd_out_layer,
    input  logic              act_valid,
    input  logic [DATA_W-1:0] act_data,
    input  logic              act_last,
    input  logic              out_full,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [PC_W-1:0]   pc;
    logic [WORD_W-1:0] mem_rdata;
    uword_t            word;
    uword_t            cur;
    logic              fire;
    logic              sig_push;
    logic              sig_pop;
    logic [DATA_W-1:0] sig_head;
    logic [CNT_W-1:0]  sig_count;
    logic [CNT_W-1:0]  infl_sig;
    logic [OUT_W-1:0]  infl_out;
    logic              mem_we;

    assign mem_we = cfg_we && !busy;
    assign word   = uword_t'(mem_rdata);

    lseq_ucode_mem #(
        .DEPTH (UCODE_DEPTH),
        .WIDTH (WORD_W)
    ) ucode_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (pc),
        .rdata (mem_rdata)
    );

    lseq_ctrl #(
        .PC_W      (PC_W),
        .SIG_DEPTH (SIG_DEPTH),
        .CNT_W     (CNT_W),
        .OUT_W     (OUT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .word      (word),
        .in_valid  (in_valid),
        .sig_count (sig_count),
        .out_full  (out_full),
        .act_valid (act_valid),
        .act_last  (act_last),
        .pc        (pc),
        .cur       (cur),
        .fire      (fire),
        .busy      (busy),
        .done_evt  (done_evt),
        .infl_sig  (infl_sig),
        .infl_out  (infl_out)
    );

    lseq_sig_fifo #(
        .DEPTH  (SIG_DEPTH),
        .DATA_W (DATA_W)
    ) sig_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sig_push),
        .din   (act_data),
        .pop   (sig_pop),
        .dout  (sig_head),
        .count (sig_count)
    );

    // Hidden-layer results feed the FIFO; output-layer results bypass it.
    assign sig_push  = act_valid && !act_last;
    assign out_valid = act_valid && act_last;
    assign out_data  = act_data;

    // Operand selection and source pops.
    assign sig_pop  = fire && cur.from_sig;
    assign in_pop   = fire && !cur.from_sig;
    assign cmd_data = cur.from_sig ? sig_head : in_data;

    // Command fields and architectural-to-physical mapping.
    assign cmd_valid     = fire;
    assign cmd_pe        = PE_W'(int'(cur.arch_id) % NUM_PE);
    assign cmd_to_act    = cur.to_act;
    assign cmd_act_type  = cur.to_act ? cur.act_type : 2'b00;
    assign cmd_out_layer = cur.to_act && cur.out_layer;
endmodule

// File: rtl/layer_seq_chk.sv
// Protocol checker for the layer sequencer, attached by bind.
module layer_seq_chk #(
    parameter int NUM_PE    = 8,
    parameter int SIG_DEPTH = 1024,
    parameter int PE_W      = 3,
    parameter int CNT_W     = 11,
    parameter int OUT_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cmd_valid,
    input logic [PE_W-1:0]  cmd_pe,
    input logic             in_pop,
    input logic             in_valid,
    input logic             sig_push,
    input logic [CNT_W-1:0] sig_count,
    input logic             done_evt,
    input logic             act_valid,
    input logic [CNT_W-1:0] infl_sig,
    input logic [OUT_W-1:0] infl_out
);
    // R1: reset leaves the unit idle and silent.
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !cmd_valid));

    // R5: no command while idle.
    p_idle_no_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    // R10: the input FIFO is only popped when it has data.
    p_pop_needs_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |-> in_valid);

    // R11: the sigmoid FIFO never receives a push while full.
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sig_push |-> (int'(sig_count) < SIG_DEPTH));

    // R6: physical element index stays inside the chain.
    p_pe_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (int'(cmd_pe) < NUM_PE));

    // R12: done changes level only as the unit goes idle.
    p_done_only_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt != $past(done_evt)) |-> !busy);

    // R9: every returned result was outstanding.
    p_ret_expected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (infl_sig != '0 || infl_out != '0));
endmodule

bind layer_seq layer_seq_chk #(
    .NUM_PE    (NUM_PE),
    .SIG_DEPTH (SIG_DEPTH),
    .PE_W      (PE_W),
    .CNT_W     (CNT_W),
    .OUT_W     (OUT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .cmd_pe    (cmd_pe),
    .in_pop    (in_pop),
    .in_valid  (in_valid),
    .sig_push  (sig_push),
    .sig_count (sig_count),
    .done_evt  (done_evt),
    .act_valid (act_valid),
    .infl_sig  (infl_sig),
    .infl_out  (infl_out)
);

// File: tb/layer_seq_tb_top.sv
// Bench: behavioural reference model compared with the design every cycle.
module layer_seq_tb_top;
    localparam int NPE  = 4;
    localparam int SDEP = 8;
    localparam int PCW  = 8;
    localparam int PEW  = 2;
    localparam int LAT  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start_evt = 1'b0;
    logic        done_evt, busy;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_pop;
    logic        cmd_valid;
    logic [PEW-1:0] cmd_pe;
    logic [15:0] cmd_data;
    logic        cmd_to_act;
    logic [1:0]  cmd_act_type;
    logic        cmd_out_layer;
    logic        act_valid = 1'b0;
    logic [15:0] act_data = '0;
    logic        act_last = 1'b0;
    logic        out_full = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;

    always #2.5 clk = ~clk;

    layer_seq #(.NUM_PE(NPE), .UCODE_DEPTH(256), .SIG_DEPTH(SDEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start_evt(start_evt), .done_evt(done_evt),
        .busy(busy), .in_valid(in_valid), .in_data(in_data), .in_pop(in_pop),
        .cmd_valid(cmd_valid), .cmd_pe(cmd_pe), .cmd_data(cmd_data),
        .cmd_to_act(cmd_to_act), .cmd_act_type(cmd_act_type),
        .cmd_out_layer(cmd_out_layer), .act_valid(act_valid),
        .act_data(act_data), .act_last(act_last), .out_full(out_full),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Bench-side stimulus requests, applied at the next falling edge.
    logic        b_rst = 1'b0, b_we = 1'b0, b_start = 1'b0, b_full = 1'b0;
    logic        b_full_pat = 1'b0, b_hold_pat = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;

    int n_chk = 0, n_fail = 0, cyc = 0, n_out = 0, n_cmd = 0;

    // Reference model state.
    int          m_state = 0;   // 0 idle, 1 fetch, 2 issue, 3 drain
    int          m_pc = 0, m_rem = 0, m_isig = 0, m_iout = 0;
    logic [31:0] m_cur = '0;
    logic        m_seen = 1'b0, m_done = 1'b0;
    logic [31:0] m_mem [256];
    int          sig_q[$];
    int          in_q[$];
    int          due_c[$];
    int          due_d[$];
    bit          due_l[$];

    function automatic logic [31:0] mk(int id, int cnt, bit fsig, bit tact, int typ, bit outl);
        logic [31:0] w;
        w = '0;
        w[7:0] = id[7:0]; w[17:8] = cnt[9:0]; w[18] = fsig; w[19] = tact;
        w[21:20] = typ[1:0]; w[22] = outl;
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] actual, logic [31:0] expect_v);
        n_chk++;
        if (actual !== expect_v) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, actual, expect_v, cyc);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_pc = 0; m_rem = 0; m_isig = 0; m_iout = 0;
        m_cur = '0; m_seen = 1'b0; m_done = 1'b0;
        sig_q.delete(); in_q.delete(); due_c.delete(); due_d.delete(); due_l.delete();
    endtask

    task automatic cycle();
        bit src_ok, dst_ok, ev, fsig, tact, outl, tog;
        int exp_data;
        @(negedge clk);
        rst_n     = !b_rst ? 1'b1 : 1'b0;
        cfg_we    = b_we; cfg_addr = b_addr; cfg_wdata = b_wdata;
        start_evt = b_start;
        out_full  = b_full_pat ? ((cyc % 7) < 3) : b_full;
        in_valid  = (in_q.size() > 0) && !(b_hold_pat && (cyc % 5 == 2));
        in_data   = (in_q.size() > 0) ? 16'(in_q[0]) : 16'h0;
        if (due_c.size() > 0 && due_c[0] == cyc) begin
            act_valid = 1'b1; act_data = 16'(due_d[0]); act_last = due_l[0];
            void'(due_c.pop_front()); void'(due_d.pop_front()); void'(due_l.pop_front());
        end else begin
            act_valid = 1'b0; act_data = '0; act_last = 1'b0;
        end
        #1;
        if (b_rst) begin
            model_reset();
        end else begin
            fsig = m_cur[18]; tact = m_cur[19]; outl = m_cur[22];
            src_ok = fsig ? (sig_q.size() > 0) : in_valid;
            dst_ok = !tact ? 1'b1 : (outl ? !out_full : ((sig_q.size() + m_isig - int'(fsig)) < SDEP));
            ev = (m_state == 2) && src_ok && dst_ok;
            exp_data = fsig ? ((sig_q.size() > 0) ? sig_q[0] : 0) : int'(in_data);
            chk("R2 busy", 32'(busy), 32'(m_state != 0));
            chk("R12 done_evt", 32'(done_evt), 32'(m_done));
            chk("R5 cmd_valid", 32'(cmd_valid), 32'(ev));
            chk("R7 in_pop", 32'(in_pop), 32'(ev && !fsig));
            chk("R9 out_valid", 32'(out_valid), 32'(act_valid && act_last));
            if (act_valid && act_last) chk("R9 out_data", 32'(out_data), 32'(act_data));
            if (ev) begin
                n_cmd++;
                chk("R6 cmd_pe", 32'(cmd_pe), 32'(int'(m_cur[7:0]) % NPE));
                chk("R7 cmd_data", 32'(cmd_data), 32'(exp_data[15:0]));
                chk("R8 cmd_to_act", 32'(cmd_to_act), 32'(tact));
                chk("R8 cmd_act_type", 32'(cmd_act_type), tact ? 32'(m_cur[21:20]) : 32'd0);
                chk("R8 cmd_out_layer", 32'(cmd_out_layer), 32'(tact && outl));
            end
            if (out_valid) n_out++;
            // state update
            if (b_we && m_state == 0) m_mem[b_addr] = b_wdata;
            tog = (b_start != m_seen);
            m_seen = b_start;
            if (ev && tact) begin
                due_c.push_back(cyc + LAT);
                due_d.push_back(int'(~exp_data[15:0]));
                due_l.push_back(outl);
                if (outl) m_iout++; else m_isig++;
            end
            if (ev && fsig) void'(sig_q.pop_front());
            if (ev && !fsig) void'(in_q.pop_front());
            if (act_valid && !act_last) begin sig_q.push_back(int'(act_data)); m_isig--; end
            if (act_valid && act_last) m_iout--;
            case (m_state)
                0: if (tog) begin m_state = 1; m_pc = 0; end
                1: begin
                    if (m_mem[m_pc][31]) m_state = 3;
                    else if (m_mem[m_pc][17:8] == 0) m_pc = (m_pc + 1) % 256;
                    else begin m_cur = m_mem[m_pc]; m_rem = int'(m_mem[m_pc][17:8]); m_state = 2; end
                end
                2: if (ev) begin
                    if (m_rem == 1) begin m_pc = (m_pc + 1) % 256; m_state = 1; end
                    else m_rem--;
                end
                default: if (m_isig == 0 && m_iout == 0 && !(act_valid)) begin
                    m_done = !m_done; m_state = 0;
                end
            endcase
        end
        cyc++;
    endtask

    task automatic wr(int a, logic [31:0] w);
        b_we = 1'b1; b_addr = a[7:0]; b_wdata = w;
        cycle();
        b_we = 1'b0;
    endtask

    task automatic run_to_idle(int limit);
        int g;
        g = 0;
        cycle();
        while ((m_state != 0 || due_c.size() > 0) && g < limit) begin
            cycle();
            g++;
        end
        if (g >= limit) begin
            n_chk++; n_fail++;
            $display("FAIL R12 watchdog: run did not finish, actual=busy expected=idle");
        end
        cycle(); cycle();
    endtask

    initial begin
        // R1: reset
        b_rst = 1'b1;
        repeat (4) cycle();
        b_rst = 1'b0;
        cycle();
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 done_evt after reset", 32'(done_evt), 32'd0);
        chk("R1 cmd_valid after reset", 32'(cmd_valid), 32'd0);
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);

        // Program A (R4 layout): hidden pass, hidden activation, zero word, output layer.
        wr(0, mk(1, 3, 0, 0, 0, 0));
        wr(1, mk(6, 3, 0, 1, 2, 0));
        wr(2, mk(0, 0, 0, 0, 0, 0));   // R5 skip
        wr(3, mk(9, 3, 1, 1, 1, 1));
        wr(4, 32'h8000_0000);
        for (int i = 0; i < 6; i++) in_q.push_back(16'h0100 + i * 16'h0011);

        // Run 1 with input gaps (R10), start by rising toggle (R2).
        b_hold_pat = 1'b1; n_out = 0;
        b_start = 1'b1;
        run_to_idle(3000);
        chk("R9 three outputs in run 1", 32'(n_out), 32'd3);
        chk("R12 done toggled after run 1", 32'(done_evt), 32'd1);
        b_hold_pat = 1'b0;

        // Run 2: falling toggle starts; extra toggle and write while busy (R2, R3).
        for (int i = 0; i < 6; i++) in_q.push_back(16'h0700 - i * 16'h0023);
        b_start = 1'b0;
        cycle(); cycle();
        b_start = 1'b1;
        wr(0, mk(2, 1, 1, 1, 3, 1));
        run_to_idle(3000);
        repeat (5) cycle();
        chk("R2 no restart from busy toggle", 32'(busy), 32'd0);

        // Run 3: original program again, with out_full bursts (R3, R11).
        for (int i = 0; i < 6; i++) in_q.push_back(16'h1234 + i * 16'h0101);
        b_full_pat = 1'b1; n_out = 0;
        b_start = 1'b0;
        run_to_idle(3000);
        chk("R3 program intact, three outputs", 32'(n_out), 32'd3);
        b_full_pat = 1'b0;

        // Run 4: next-element burst never waits for out_full (R11).
        wr(0, mk(13, 4, 0, 0, 0, 0));
        wr(1, 32'h8000_0000);
        for (int i = 0; i < 4; i++) in_q.push_back(16'h0040 + i);
        b_full = 1'b1; n_cmd = 0;
        b_start = 1'b1;
        repeat (7) cycle();
        chk("R11 next-element burst issued under out_full", 32'(n_cmd), 32'd4);
        run_to_idle(3000);
        b_full = 1'b0;

        // Run 5: fill sigmoid FIFO to its depth, then stall on room (R11).
        wr(0, mk(3, SDEP, 0, 1, 0, 0));
        wr(1, mk(1, 2, 1, 1, 0, 1));
        wr(2, mk(7, 3, 0, 1, 2, 0));
        wr(3, 32'h8000_0000);
        for (int i = 0; i < SDEP + 3; i++) in_q.push_back(16'h0200 + i);
        n_cmd = 0;
        b_start = 1'b0;
        repeat (60) cycle();
        chk("R11 stalled at FIFO limit", 32'(n_cmd), 32'(SDEP + 2 + 2));
        chk("R11 still busy while stalled", 32'(busy), 32'd1);

        // Mid-run reset (R1).
        b_rst = 1'b1;
        cycle();
        b_rst = 1'b0;
        cycle();
        chk("R1 busy after mid-run reset", 32'(busy), 32'd0);
        chk("R1 done_evt after mid-run reset", 32'(done_evt), 32'd0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #900000;
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog expired: actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule